// File: doc/BRIEF.md
# Timer-Watchdog Event Router

This block takes the one-cycle end-of-count pulse of a timer/watchdog counter, an asynchronous external interrupt pin and a synchronous external reset request, and steers them to three destinations: a stretched system reset, a pending latch for the top-level non-maskable interrupt, and a pending latch for interrupt channel A0 of an external interrupt controller. Three configuration inputs pick the routing. The first is the counter mode: 0 means watchdog and 1 means timer. The second picks the A0 source and the third picks the top-level source. For both selects, 0 means the counter and 1 means the pin.

In watchdog mode an end-of-count resets the system and sets a sticky flag that records the watchdog reset. In timer mode the end-of-count is offered as an interrupt source. If both selects point at the counter, only A0 is raised. Software can set either pending latch to create a trap. Software clears each latch with a clear strobe, and clears the flag the same way. The block itself is reset only by its own power-on reset input. The reset it drives does not clear its own state.

Top module: `wdt_event_router`

## Requirements
- R1: After power-on reset (`rst_n` low at a clock edge) all four outputs are 0.
- R2: With `cfg_mode`=0, an `eoc_pulse` sampled at an edge makes `sys_rst_out` 1 from that edge for exactly 4 cycles and sets `wd_reset_flag`. No pending bit is set by it.
- R3: An `ext_rst_req` sampled at an edge makes `sys_rst_out` 1 for exactly 4 cycles, in either mode, and leaves `wd_reset_flag` unchanged.
- R4: With `cfg_mode`=1, an end-of-count never asserts `sys_rst_out` and never sets `wd_reset_flag`.
- R5: With `cfg_a0_pin`=1, a rising edge on `ext_pin` sets `a0_pending` at the third clock edge after the rise. A pin held high sets it only once.
- R6: With `cfg_top_pin`=1, a pin rising edge sets `top_pending` in either mode. With `cfg_mode`=1, `cfg_top_pin`=0 and `cfg_a0_pin`=1, an end-of-count sets `top_pending`.
- R7: With `cfg_mode`=1 and both selects 0, an end-of-count sets `a0_pending` only. `top_pending` stays 0.
- R8: With `cfg_mode`=0, a destination whose select is 0 has no hardware source. Its pending bit changes only by software.
- R9: `sw_set_a0` or `sw_set_top` sets the matching pending bit at the next edge, in any mode and with any select.
- R10: A pending bit stays 1 until its clear strobe. If a set and a clear arrive in the same cycle, the set wins.
- R11: `wd_reset_flag` stays 1 through the reset it records. It is cleared only by `sw_clr_wdflag` or `rst_n`. A watchdog reset cause and `sw_clr_wdflag` in the same cycle leave it set.
- R12: A reset cause that arrives while `sys_rst_out` is 1 restarts the 4-cycle hold from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cfg_mode | input | 1 | 0 watchdog mode, 1 timer mode |
| cfg_a0_pin | input | 1 | A0 source: 0 counter, 1 pin |
| cfg_top_pin | input | 1 | Top-level source: 0 counter, 1 pin |
| eoc_pulse | input | 1 | One-cycle counter end-of-count |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| ext_rst_req | input | 1 | Synchronous external reset request |
| sw_set_a0 | input | 1 | Software trap: set A0 pending |
| sw_set_top | input | 1 | Software trap: set top-level pending |
| sw_clr_a0 | input | 1 | Clear A0 pending |
| sw_clr_top | input | 1 | Clear top-level pending |
| sw_clr_wdflag | input | 1 | Clear watchdog-reset flag |
| a0_pending | output | 1 | A0 interrupt request latch |
| top_pending | output | 1 | Top-level non-maskable request latch |
| sys_rst_out | output | 1 | Stretched system reset |
| wd_reset_flag | output | 1 | Sticky watchdog-reset record |

## Verification
A wrong route shows on the next clock edge as a pending bit that rises when it should not, or fails to rise. The clearest cases are the conflict case with both selects at the counter and watchdog mode, where a counter-selected destination must stay quiet. A fault in the reset counter shows as a reset pulse of the wrong length, which is visible within five cycles of the cause, or as a retriggered pulse that ends early. A fault in the synchroniser shows as a pin latency other than three edges, or as repeated setting while the pin is held high.

// File: rtl/wdr_pkg.sv
// Package: shared types and destination indices for the timer-watchdog event router.
// Assumes: two interrupt destinations; all selects are single bits.
package wdr_pkg;

    typedef enum logic {
        MODE_WATCHDOG = 1'b0,
        MODE_TIMER    = 1'b1
    } cnt_mode_e;

    typedef enum logic {
        SRC_COUNTER = 1'b0,
        SRC_PIN     = 1'b1
    } irq_src_e;

    typedef struct packed {
        cnt_mode_e mode;
        irq_src_e  a0_src;
        irq_src_e  top_src;
    } route_cfg_t;

    localparam int NUM_DEST = 2;
    localparam int DEST_A0  = 0;
    localparam int DEST_TOP = 1;

endpackage

// File: rtl/wdr_pin_sync.sv
// Module: wdr_pin_sync
// Brings an asynchronous pin into the clock domain through a chain of flip-flops
// and emits a one-cycle pulse on each rising edge of the synchronised level.
// Assumes: STAGES >= 2; pin pulses last longer than one clock period.
module wdr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_rise
);
    logic [STAGES-1:0] chain;
    logic              last_lvl;

    // Shift the pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], pin_async};
        end
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_lvl <= 1'b0;
        end else begin
            last_lvl <= chain[STAGES-1];
        end
    end

    // Rising edge of the synchronised level.
    always_comb begin
        pin_rise = chain[STAGES-1] & ~last_lvl;
    end

endmodule

// File: rtl/wdr_route.sv
// Module: wdr_route
// Combinational steering of end-of-count and pin edges to the reset cause and
// the hardware set lines of the pending latches.
// Assumes: eoc is a single-cycle pulse; pin_rise is already synchronous.
module wdr_route
    import wdr_pkg::*;
(
    input  route_cfg_t          cfg,
    input  logic                eoc,
    input  logic                pin_rise,
    output logic [NUM_DEST-1:0] hw_set,
    output logic                wd_cause
);
    logic timer_eoc;

    // Split the end-of-count by counter mode.
    always_comb begin
        timer_eoc = (cfg.mode == MODE_TIMER) & eoc;
        wd_cause  = (cfg.mode == MODE_WATCHDOG) & eoc;
    end

    // A0 takes the pin or the timer end-of-count.
    always_comb begin
        if (cfg.a0_src == SRC_PIN) begin
            hw_set[DEST_A0] = pin_rise;
        end else begin
            hw_set[DEST_A0] = timer_eoc;
        end
    end

    // Top level takes the pin, or the end-of-count only when A0 does not claim it.
    always_comb begin
        if (cfg.top_src == SRC_PIN) begin
            hw_set[DEST_TOP] = pin_rise;
        end else begin
            hw_set[DEST_TOP] = timer_eoc & (cfg.a0_src == SRC_PIN);
        end
    end

endmodule

// File: rtl/wdr_pending.sv
// Module: wdr_pending
// One set/clear latch per destination; set (hardware or software) beats clear.
// Assumes: strobes are single-cycle and synchronous.
module wdr_pending #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_dest
        // Per-destination latch: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
            end else if (hw_set[i] || sw_set[i]) begin
                pend[i] <= 1'b1;
            end else if (sw_clr[i]) begin
                pend[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdr_rst_stretch.sv
// Module: wdr_rst_stretch
// Holds the system reset output for HOLD cycles after any cause and records
// watchdog-caused resets in a sticky flag that only power-on or software clears.
// Assumes: HOLD >= 1; causes are synchronous.
module wdr_rst_stretch #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_cause,
    input  logic ext_cause,
    input  logic flag_clr,
    output logic rst_out,
    output logic wd_flag
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] remain;

    // Reload on any cause, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (wd_cause || ext_cause) begin
            remain <= CW'(HOLD);
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    // Sticky watchdog-reset record; a new cause beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_flag <= 1'b0;
        end else if (wd_cause) begin
            wd_flag <= 1'b1;
        end else if (flag_clr) begin
            wd_flag <= 1'b0;
        end
    end

    // Reset is active while the hold count is non-zero.
    always_comb begin
        rst_out = (remain != '0);
    end

endmodule

// File: rtl/wdt_event_router.sv
// Module: wdt_event_router
// Top level: routes a timer/watchdog end-of-count, an external pin and an external
// reset request to a stretched system reset and two interrupt pending latches.
// Assumes: rst_n is the power-on reset only; sys_rst_out does not reset this block.
module wdt_event_router
    import wdr_pkg::*;
#(
    parameter int RST_HOLD    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_mode,
    input  logic cfg_a0_pin,
    input  logic cfg_top_pin,
    input  logic eoc_pulse,
    input  logic ext_pin,
    input  logic ext_rst_req,
    input  logic sw_set_a0,
    input  logic sw_set_top,
    input  logic sw_clr_a0,
    input  logic sw_clr_top,
    input  logic sw_clr_wdflag,
    output logic a0_pending,
    output logic top_pending,
    output logic sys_rst_out,
    output logic wd_reset_flag
);
    route_cfg_t          cfg;
    logic                pin_rise;
    logic                wd_cause;
    logic [NUM_DEST-1:0] hw_set;
    logic [NUM_DEST-1:0] sw_set;
    logic [NUM_DEST-1:0] sw_clr;
    logic [NUM_DEST-1:0] pend;

    // Pack the configuration and software strobes by destination index.
    always_comb begin
        cfg.mode          = cnt_mode_e'(cfg_mode);
        cfg.a0_src        = irq_src_e'(cfg_a0_pin);
        cfg.top_src       = irq_src_e'(cfg_top_pin);
        sw_set[DEST_A0]   = sw_set_a0;
        sw_set[DEST_TOP]  = sw_set_top;
        sw_clr[DEST_A0]   = sw_clr_a0;
        sw_clr[DEST_TOP]  = sw_clr_top;
        a0_pending        = pend[DEST_A0];
        top_pending       = pend[DEST_TOP];
    end

    wdr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (ext_pin),
        .pin_rise  (pin_rise)
    );

    wdr_route u_route (
        .cfg      (cfg),
        .eoc      (eoc_pulse),
        .pin_rise (pin_rise),
        .hw_set   (hw_set),
        .wd_cause (wd_cause)
    );

    wdr_pending #(.N(NUM_DEST)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (hw_set),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .pend   (pend)
    );

    wdr_rst_stretch #(.HOLD(RST_HOLD)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .wd_cause  (wd_cause),
        .ext_cause (ext_rst_req),
        .flag_clr  (sw_clr_wdflag),
        .rst_out   (sys_rst_out),
        .wd_flag   (wd_reset_flag)
    );

endmodule

// File: rtl/wdt_event_router_chk.sv
// Module: wdt_event_router_chk
// Port-level properties of the router, bound into every instance of the top.
module wdt_event_router_chk #(
    parameter int HOLD = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_mode,
    input logic cfg_a0_pin,
    input logic cfg_top_pin,
    input logic eoc_pulse,
    input logic ext_rst_req,
    input logic sw_set_a0,
    input logic sw_set_top,
    input logic sw_clr_a0,
    input logic sw_clr_top,
    input logic sw_clr_wdflag,
    input logic a0_pending,
    input logic top_pending,
    input logic sys_rst_out,
    input logic wd_reset_flag
);
    localparam int SW = $clog2(HOLD + 2);

    logic [SW-1:0] since_cause;

    // Cycles since the last reset cause, saturating at HOLD.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_cause <= SW'(HOLD);
        end else if ((eoc_pulse && !cfg_mode) || ext_rst_req) begin
            since_cause <= '0;
        end else if (since_cause < SW'(HOLD)) begin
            since_cause <= since_cause + SW'(1);
        end
    end

    p_wd_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_pulse && !cfg_mode) |=> (sys_rst_out && wd_reset_flag));

    p_ext_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_req |=> sys_rst_out);

    p_timer_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_reset_flag && !(eoc_pulse && !cfg_mode)) |=> !wd_reset_flag);

    p_conflict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && !cfg_a0_pin && !cfg_top_pin && !sw_set_top && !top_pending)
        |=> !top_pending);

    p_wd_no_hw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && !cfg_a0_pin && !sw_set_a0 && !a0_pending) |=> !a0_pending);

    p_sw_set_a0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set_a0 |=> a0_pending);

    p_sw_set_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set_top |=> top_pending);

    p_a0_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (a0_pending && !sw_clr_a0) |=> a0_pending);

    p_top_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (top_pending && !sw_clr_top) |=> top_pending);

    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_reset_flag && !sw_clr_wdflag) |=> wd_reset_flag);

    p_hold_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_out == (since_cause < SW'(HOLD)));

endmodule

bind wdt_event_router wdt_event_router_chk #(.HOLD(RST_HOLD)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode      (cfg_mode),
    .cfg_a0_pin    (cfg_a0_pin),
    .cfg_top_pin   (cfg_top_pin),
    .eoc_pulse     (eoc_pulse),
    .ext_rst_req   (ext_rst_req),
    .sw_set_a0     (sw_set_a0),
    .sw_set_top    (sw_set_top),
    .sw_clr_a0     (sw_clr_a0),
    .sw_clr_top    (sw_clr_top),
    .sw_clr_wdflag (sw_clr_wdflag),
    .a0_pending    (a0_pending),
    .top_pending   (top_pending),
    .sys_rst_out   (sys_rst_out),
    .wd_reset_flag (wd_reset_flag)
);

// File: tb/wdt_event_router_test.sv
`timescale 1ns/1ps
module wdt_event_router_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_mode = 1'b0, cfg_a0_pin = 1'b0, cfg_top_pin = 1'b0;
    logic eoc_pulse = 1'b0, ext_pin = 1'b0, ext_rst_req = 1'b0;
    logic sw_set_a0 = 1'b0, sw_set_top = 1'b0, sw_clr_a0 = 1'b0, sw_clr_top = 1'b0;
    logic sw_clr_wdflag = 1'b0;
    logic a0_pending, top_pending, sys_rst_out, wd_reset_flag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    wdt_event_router uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_a0_pin(cfg_a0_pin),
        .cfg_top_pin(cfg_top_pin), .eoc_pulse(eoc_pulse), .ext_pin(ext_pin),
        .ext_rst_req(ext_rst_req), .sw_set_a0(sw_set_a0), .sw_set_top(sw_set_top),
        .sw_clr_a0(sw_clr_a0), .sw_clr_top(sw_clr_top), .sw_clr_wdflag(sw_clr_wdflag),
        .a0_pending(a0_pending), .top_pending(top_pending),
        .sys_rst_out(sys_rst_out), .wd_reset_flag(wd_reset_flag)
    );

    // Vector: {mode, a0_sel, top_sel, exp_a0, exp_top, exp_rst, exp_flag}
    localparam logic [6:0] VEC [8] = '{
        7'b000_0011, 7'b001_0011, 7'b010_0011, 7'b011_0011,
        7'b100_1000, 7'b101_1000, 7'b110_0100, 7'b111_0000
    };

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk);
        sw_clr_a0 = 1'b1; sw_clr_top = 1'b1; sw_clr_wdflag = 1'b1;
        @(negedge clk);
        sw_clr_a0 = 1'b0; sw_clr_top = 1'b0; sw_clr_wdflag = 1'b0;
    endtask

    task automatic pulse_eoc();
        @(negedge clk) eoc_pulse = 1'b1;
        @(negedge clk) eoc_pulse = 1'b0;
    endtask

    task automatic pulse_ext();
        @(negedge clk) ext_rst_req = 1'b1;
        @(negedge clk) ext_rst_req = 1'b0;
    endtask

    task automatic count_rst(output int n);
        n = 0;
        while (sys_rst_out && n < 50) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        string req;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1", "a0_pending", a0_pending, 0);
        chk("R1", "top_pending", top_pending, 0);
        chk("R1", "sys_rst_out", sys_rst_out, 0);
        chk("R1", "wd_reset_flag", wd_reset_flag, 0);

        // Table walk: routing of one end-of-count under each configuration
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            cfg_mode = VEC[v][6]; cfg_a0_pin = VEC[v][5]; cfg_top_pin = VEC[v][4];
            clear_all();
            pulse_eoc();
            if (!VEC[v][6]) req = "R8";
            else if (!VEC[v][5] && !VEC[v][4]) req = "R7";
            else if (VEC[v][5] && !VEC[v][4]) req = "R6";
            else req = "R4";
            chk(req, $sformatf("vec%0d a0", v), a0_pending, VEC[v][3]);
            chk(req, $sformatf("vec%0d top", v), top_pending, VEC[v][2]);
            chk(VEC[v][6] ? "R4" : "R2", $sformatf("vec%0d rst", v), sys_rst_out, VEC[v][1]);
            chk(VEC[v][6] ? "R4" : "R2", $sformatf("vec%0d flag", v), wd_reset_flag, VEC[v][0]);
            tick(6);
        end

        // R2 watchdog reset length
        cfg_mode = 1'b0; cfg_a0_pin = 1'b0; cfg_top_pin = 1'b0;
        clear_all();
        pulse_eoc();
        count_rst(n);
        chk("R2", "watchdog reset length", n, 4);

        // R3 external reset length, flag untouched, timer mode
        cfg_mode = 1'b1;
        clear_all();
        pulse_ext();
        count_rst(n);
        chk("R3", "external reset length", n, 4);
        chk("R3", "flag after external reset", wd_reset_flag, 0);

        // R12 retrigger restarts the hold
        pulse_ext();
        tick(1);
        chk("R12", "reset still high before retrigger", sys_rst_out, 1);
        pulse_ext();
        count_rst(n);
        chk("R12", "hold after retrigger", n, 4);

        // R5 pin to A0: three-edge latency, edge only
        cfg_mode = 1'b1; cfg_a0_pin = 1'b1; cfg_top_pin = 1'b0;
        clear_all();
        @(negedge clk) ext_pin = 1'b1;
        @(negedge clk);
        chk("R5", "a0 after edge 1", a0_pending, 0);
        @(negedge clk);
        chk("R5", "a0 after edge 2", a0_pending, 0);
        @(negedge clk);
        chk("R5", "a0 after edge 3", a0_pending, 1);
        chk("R5", "top untouched by pin", top_pending, 0);
        clear_all();
        tick(5);
        chk("R5", "a0 with pin held high", a0_pending, 0);
        ext_pin = 1'b0;
        tick(4);

        // R6 pin to top level in watchdog mode; A0 on counter gets nothing (R8)
        cfg_mode = 1'b0; cfg_a0_pin = 1'b0; cfg_top_pin = 1'b1;
        clear_all();
        @(negedge clk) ext_pin = 1'b1;
        tick(3);
        chk("R6", "top from pin in watchdog mode", top_pending, 1);
        chk("R8", "a0 on counter in watchdog mode", a0_pending, 0);
        ext_pin = 1'b0;
        tick(4);

        // R9 software traps in watchdog mode with counter selects
        cfg_top_pin = 1'b0;
        clear_all();
        @(negedge clk) sw_set_a0 = 1'b1;
        @(negedge clk) sw_set_a0 = 1'b0;
        chk("R9", "sw trap a0", a0_pending, 1);
        @(negedge clk) sw_set_top = 1'b1;
        @(negedge clk) sw_set_top = 1'b0;
        chk("R9", "sw trap top", top_pending, 1);

        // R10 clear alone, then set and clear together
        @(negedge clk) sw_clr_a0 = 1'b1;
        @(negedge clk) sw_clr_a0 = 1'b0;
        chk("R10", "a0 after clear", a0_pending, 0);
        chk("R10", "top kept while a0 cleared", top_pending, 1);
        @(negedge clk) begin sw_set_a0 = 1'b1; sw_clr_a0 = 1'b1; end
        @(negedge clk) begin sw_set_a0 = 1'b0; sw_clr_a0 = 1'b0; end
        chk("R10", "set wins over clear", a0_pending, 1);

        // R11 flag sticky through its reset, cleared by software, set wins
        clear_all();
        pulse_eoc();
        tick(8);
        chk("R11", "flag after reset window", wd_reset_flag, 1);
        @(negedge clk) sw_clr_wdflag = 1'b1;
        @(negedge clk) sw_clr_wdflag = 1'b0;
        chk("R11", "flag after sw clear", wd_reset_flag, 0);
        @(negedge clk) begin eoc_pulse = 1'b1; sw_clr_wdflag = 1'b1; end
        @(negedge clk) begin eoc_pulse = 1'b0; sw_clr_wdflag = 1'b0; end
        chk("R11", "cause beats clear", wd_reset_flag, 1);
        tick(6);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk("R11", "flag after power-on reset", wd_reset_flag, 0);
        chk("R1", "a0 after power-on reset", a0_pending, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule